// File: doc/BRIEF.md
# Three-Channel Multi-Mode Timer Bank

This block holds three independent 32-bit timers behind a small word-addressed register interface. Each timer owns one pin, shown at the top as an input, an output and an output enable, and the pin's role follows the timer's mode. In waveform mode the timer drives a periodic pulse. In capture mode it measures an incoming pulse's high time and its rise-to-rise period. In watchdog mode it treats each rising edge as a heartbeat and flags a missed one.

One shared control word starts, stops and reports every timer. It also holds a sticky overflow flag per timer, which is cleared by writing one to it. Every timer has a one-cycle interrupt output that pulses on each period, capture or timeout.

Pin inputs are taken as already synchronous to `clk`. Register reads are combinational from the address. A write takes effect at the next rising clock edge.

Top module: `gp_timer_bank`

## Requirements
- R1: Word address 0 is the control word. Timer t (0..2) occupies words 4+4t to 7+4t: +0 configuration (6 bits, read back zero-extended), +1 count (read-only), +2 period, +3 pulse width. Any other address reads 0. The three timers do not affect one another.
- R2: After reset every register and status bit is 0, no pin is driven, every pin output is low and no interrupt is raised.
- R3: A control-word write with bit t set starts timer t and clears its count to 0. Bit 4+t stops timer t, and stop wins if both bits are set. Reading the control word returns the running flags in bits 2:0 and the overflow flags in bits 10:8.
- R4: Configuration bits 1:0 select the mode: 00 idle, 01 waveform, 10 capture, 11 watchdog. The pin output enable is high only in waveform mode. In idle mode the count holds.
- R5: In waveform mode, while running, the count rises by one per clock. When count+1 reaches or passes the period, the count becomes 0 instead. The pin output is high exactly while running with count below the pulse width.
- R6: A waveform wrap raises the interrupt for one cycle, in the cycle after the wrap.
- R7: In capture mode a rising pin edge restarts the count at 1. A falling edge after a rising edge stores the count into the width register. A rising edge after an earlier rising edge stores the count into the period register. Each store raises a one-cycle interrupt. A pulse sampled high for H clocks within a cycle of P clocks yields width H and period P.
- R8: In watchdog mode a rising edge returns the count to 0. When count+1 reaches the period with no edge, the count returns to 0, the interrupt pulses and the timer's overflow flag is set.
- R9: Writing one to control bit 8+t clears overflow flag t. A new overflow in the same cycle wins over the clear.
- R10: A stopped timer freezes its count and its captures, keeps its pin output low and raises no interrupt from the cycle after the stop.
- R11: Software writes to the period and width registers act at the next edge. A capture in the same cycle takes priority over them. Writes to the count address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| tmr_pin_i | input | 3 | Sampled pin level per timer |
| tmr_pin_o | output | 3 | Pin drive value per timer |
| tmr_pin_oe_o | output | 3 | Pin drive enable per timer |
| tmr_irq_o | output | 3 | One-cycle interrupt per timer |

## Verification
The bound assertions check five things on every cycle:
- a start leaves the count at zero;
- a stop silences the interrupt at once;
- an interrupt only appears on a running timer;
- a new overflow flag always comes with an interrupt;
- a clear removes the flag unless a fresh timeout coincides.

Whether the waveform duty, the measured widths and periods, the watchdog timeout instant and the write priorities are right can only be shown by the bench's scenarios. There, a behavioural model predicts pins, interrupts and read data on every clock.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_WAVE = 2'b01,
        MODE_CAPT = 2'b10,
        MODE_WDOG = 2'b11
    } gpt_mode_e;

    localparam int CFG_W      = 6;
    localparam int FIELD_SPAN = 4;

endpackage

// File: rtl/gpt_regif.sv
module gpt_regif
    import gpt_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [NUM_TMR-1:0]                en_bits_i,
    input  logic [NUM_TMR-1:0]                dis_bits_i,
    input  logic [NUM_TMR-1:0]                clr_bits_i,
    output logic [NUM_TMR-1:0]                start_o,
    output logic [NUM_TMR-1:0]                stop_o,
    output logic [NUM_TMR-1:0]                clr_o,
    output logic [NUM_TMR-1:0]                cfg_we_o,
    output logic [NUM_TMR-1:0]                per_we_o,
    output logic [NUM_TMR-1:0]                wid_we_o,
    input  logic [NUM_TMR-1:0]                run_i,
    input  logic [NUM_TMR-1:0]                ovf_i,
    input  logic [NUM_TMR-1:0][CFG_W-1:0]     cfg_i,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]     cnt_i,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]     per_i,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]     wid_i,
    output logic [CNT_W-1:0]                  rdata_o
);
    localparam int SLOT_W = ADDR_W - 2;

    logic              ctrl_wr;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        fld;

    assign ctrl_wr = wr_i && (addr_i == '0);
    assign slot    = addr_i[ADDR_W-1:2];
    assign fld     = addr_i[1:0];

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
        logic sel;
        assign sel         = (slot == SLOT_W'(i + 1));
        assign start_o[i]  = ctrl_wr && en_bits_i[i];
        assign stop_o[i]   = ctrl_wr && dis_bits_i[i];
        assign clr_o[i]    = ctrl_wr && clr_bits_i[i];
        assign cfg_we_o[i] = wr_i && sel && (fld == 2'd0);
        assign per_we_o[i] = wr_i && sel && (fld == 2'd2);
        assign wid_we_o[i] = wr_i && sel && (fld == 2'd3);
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == '0) begin
            rdata_o[NUM_TMR-1:0]              = run_i;
            rdata_o[2*FIELD_SPAN +: NUM_TMR]  = ovf_i;
        end else begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (slot == SLOT_W'(i + 1)) begin
                    unique case (fld)
                        2'd0:    rdata_o = CNT_W'(cfg_i[i]);
                        2'd1:    rdata_o = cnt_i[i];
                        2'd2:    rdata_o = per_i[i];
                        default: rdata_o = wid_i[i];
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clr_i,
    input  logic             cfg_we_i,
    input  logic             per_we_i,
    input  logic             wid_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             irq_o,
    output logic             run_o,
    output logic             ovf_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] width_o
);
    typedef struct packed {
        logic             run;
        logic             armed;
        logic             pin_prev;
        logic             irq;
        logic             ovf;
        logic [CFG_W-1:0] cfg;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
    } chan_state_t;

    chan_state_t s_d, s_q;
    gpt_mode_e   mode_q;
    logic        rise, fall, evt, ovf_set, hit;
    logic [CNT_W:0] cnt_inc;

    assign mode_q  = gpt_mode_e'(s_q.cfg[1:0]);
    assign rise    = pin_i && !s_q.pin_prev;
    assign fall    = !pin_i && s_q.pin_prev;
    assign cnt_inc = {1'b0, s_q.count} + (CNT_W + 1)'(1);
    assign hit     = cnt_inc >= {1'b0, s_q.period};

    always_comb begin
        s_d          = s_q;
        evt          = 1'b0;
        ovf_set      = 1'b0;
        s_d.pin_prev = pin_i;

        if (cfg_we_i) s_d.cfg    = wdata_i[CFG_W-1:0];
        if (per_we_i) s_d.period = wdata_i;
        if (wid_we_i) s_d.width  = wdata_i;

        if (stop_i) begin
            s_d.run = 1'b0;
        end else if (start_i) begin
            s_d.run   = 1'b1;
            s_d.count = '0;
            s_d.armed = 1'b0;
        end else if (s_q.run) begin
            unique case (mode_q)
                MODE_WAVE: begin
                    if (hit) begin
                        s_d.count = '0;
                        evt       = 1'b1;
                    end else begin
                        s_d.count = cnt_inc[CNT_W-1:0];
                    end
                end
                MODE_CAPT: begin
                    if (rise) begin
                        if (s_q.armed) begin
                            s_d.period = s_q.count;
                            evt        = 1'b1;
                        end
                        s_d.armed = 1'b1;
                        s_d.count = CNT_W'(1);
                    end else begin
                        if (fall && s_q.armed) begin
                            s_d.width = s_q.count;
                            evt       = 1'b1;
                        end
                        s_d.count = cnt_inc[CNT_W-1:0];
                    end
                end
                MODE_WDOG: begin
                    if (rise) begin
                        s_d.count = '0;
                    end else if (hit) begin
                        s_d.count = '0;
                        evt       = 1'b1;
                        ovf_set   = 1'b1;
                    end else begin
                        s_d.count = cnt_inc[CNT_W-1:0];
                    end
                end
                default: ;
            endcase
        end

        s_d.irq = evt;
        if (ovf_set)    s_d.ovf = 1'b1;
        else if (clr_i) s_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_oe_o = (mode_q == MODE_WAVE);
    assign pin_o    = s_q.run && (mode_q == MODE_WAVE) && (s_q.count < s_q.width);
    assign irq_o    = s_q.irq;
    assign run_o    = s_q.run;
    assign ovf_o    = s_q.ovf;
    assign cfg_o    = s_q.cfg;
    assign count_o  = s_q.count;
    assign period_o = s_q.period;
    assign width_o  = s_q.width;

endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
    import gpt_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [CNT_W-1:0]   bus_wdata_i,
    output logic [CNT_W-1:0]   bus_rdata_o,
    input  logic [NUM_TMR-1:0] tmr_pin_i,
    output logic [NUM_TMR-1:0] tmr_pin_o,
    output logic [NUM_TMR-1:0] tmr_pin_oe_o,
    output logic [NUM_TMR-1:0] tmr_irq_o
);
    logic [NUM_TMR-1:0]            start_v, stop_v, clr_v;
    logic [NUM_TMR-1:0]            cfg_we, per_we, wid_we;
    logic [NUM_TMR-1:0]            run_vec, ovf_vec;
    logic [NUM_TMR-1:0][CFG_W-1:0] cfg_arr;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_arr, per_arr, wid_arr;

    gpt_regif #(
        .NUM_TMR(NUM_TMR),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .en_bits_i (bus_wdata_i[NUM_TMR-1:0]),
        .dis_bits_i(bus_wdata_i[FIELD_SPAN +: NUM_TMR]),
        .clr_bits_i(bus_wdata_i[2*FIELD_SPAN +: NUM_TMR]),
        .start_o   (start_v),
        .stop_o    (stop_v),
        .clr_o     (clr_v),
        .cfg_we_o  (cfg_we),
        .per_we_o  (per_we),
        .wid_we_o  (wid_we),
        .run_i     (run_vec),
        .ovf_i     (ovf_vec),
        .cfg_i     (cfg_arr),
        .cnt_i     (cnt_arr),
        .per_i     (per_arr),
        .wid_i     (wid_arr),
        .rdata_o   (bus_rdata_o)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        gpt_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_v[i]),
            .stop_i  (stop_v[i]),
            .clr_i   (clr_v[i]),
            .cfg_we_i(cfg_we[i]),
            .per_we_i(per_we[i]),
            .wid_we_i(wid_we[i]),
            .wdata_i (bus_wdata_i),
            .pin_i   (tmr_pin_i[i]),
            .pin_o   (tmr_pin_o[i]),
            .pin_oe_o(tmr_pin_oe_o[i]),
            .irq_o   (tmr_irq_o[i]),
            .run_o   (run_vec[i]),
            .ovf_o   (ovf_vec[i]),
            .cfg_o   (cfg_arr[i]),
            .count_o (cnt_arr[i]),
            .period_o(per_arr[i]),
            .width_o (wid_arr[i])
        );
    end

endmodule

// File: rtl/gpt_bank_chk.sv
module gpt_bank_chk #(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr_i,
    input logic [ADDR_W-1:0]             bus_addr_i,
    input logic [NUM_TMR-1:0]            en_i,
    input logic [NUM_TMR-1:0]            dis_i,
    input logic [NUM_TMR-1:0]            clr_i,
    input logic [NUM_TMR-1:0]            irq_i,
    input logic [NUM_TMR-1:0]            run_i,
    input logic [NUM_TMR-1:0]            ovf_i,
    input logic [NUM_TMR-1:0][CNT_W-1:0] count_i
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr_i && (bus_addr_i == '0);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && en_i[i] && !dis_i[i]) |=> (run_i[i] && count_i[i] == '0));

        assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && dis_i[i]) |=> (!run_i[i] && !irq_i[i]));

        assert_irq_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_i[i] |-> run_i[i]);

        assert_ovf_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_i[i]) |-> irq_i[i]);

        assert_ovf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && clr_i[i]) |=> (!ovf_i[i] || irq_i[i]));
    end

endmodule

bind gp_timer_bank gpt_bank_chk #(
    .NUM_TMR(NUM_TMR),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_i  (bus_wr_i),
    .bus_addr_i(bus_addr_i),
    .en_i      (bus_wdata_i[NUM_TMR-1:0]),
    .dis_i     (bus_wdata_i[4 +: NUM_TMR]),
    .clr_i     (bus_wdata_i[8 +: NUM_TMR]),
    .irq_i     (tmr_irq_o),
    .run_i     (run_vec),
    .ovf_i     (ovf_vec),
    .count_i   (cnt_arr)
);

// File: tb/tb_gp_timer_bank.sv
`timescale 1ns/100ps
module tb_gp_timer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic [3:0]  b_addr = '0;
    logic [31:0] b_wd = '0;
    logic [2:0]  b_pin = '0;
    logic [31:0] rdata;
    logic [2:0]  pin_o, pin_oe, irq;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    gp_timer_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(b_wr), .bus_addr_i(b_addr),
        .bus_wdata_i(b_wd), .bus_rdata_o(rdata), .tmr_pin_i(b_pin),
        .tmr_pin_o(pin_o), .tmr_pin_oe_o(pin_oe), .tmr_irq_o(irq)
    );

    // behavioural reference state
    bit     m_run[3], m_arm[3], m_prev[3], m_irq[3], m_ovf[3];
    longint m_cnt[3], m_per[3], m_wid[3];
    int     m_cfg[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 3; t++) begin
                m_run[t] = 0; m_arm[t] = 0; m_prev[t] = 0; m_irq[t] = 0; m_ovf[t] = 0;
                m_cnt[t] = 0; m_per[t] = 0; m_wid[t] = 0; m_cfg[t] = 0;
            end
        end else begin
            for (int t = 0; t < 3; t++) begin
                bit rise, fall, ev, ovs, ctrl;
                int md;
                longint nx, old_per, old_cnt;
                rise = b_pin[t] && !m_prev[t];
                fall = !b_pin[t] && m_prev[t];
                md = m_cfg[t] % 4;
                old_per = m_per[t];
                old_cnt = m_cnt[t];
                nx = old_cnt + 1;
                ev = 0; ovs = 0;
                ctrl = b_wr && (b_addr == 0);
                if (b_wr && b_addr == 4 + 4 * t) m_cfg[t] = b_wd & 63;
                if (b_wr && b_addr == 6 + 4 * t) m_per[t] = b_wd;
                if (b_wr && b_addr == 7 + 4 * t) m_wid[t] = b_wd;
                if (ctrl && b_wd[4 + t]) m_run[t] = 0;
                else if (ctrl && b_wd[t]) begin
                    m_run[t] = 1; m_cnt[t] = 0; m_arm[t] = 0;
                end else if (m_run[t]) begin
                    if (md == 1) begin
                        if (nx >= old_per) begin m_cnt[t] = 0; ev = 1; end
                        else m_cnt[t] = nx;
                    end else if (md == 2) begin
                        if (rise) begin
                            if (m_arm[t]) begin m_per[t] = old_cnt; ev = 1; end
                            m_arm[t] = 1; m_cnt[t] = 1;
                        end else begin
                            if (fall && m_arm[t]) begin m_wid[t] = old_cnt; ev = 1; end
                            m_cnt[t] = nx;
                        end
                    end else if (md == 3) begin
                        if (rise) m_cnt[t] = 0;
                        else if (nx >= old_per) begin m_cnt[t] = 0; ev = 1; ovs = 1; end
                        else m_cnt[t] = nx;
                    end
                end
                m_irq[t] = ev;
                if (ovs) m_ovf[t] = 1;
                else if (ctrl && b_wd[8 + t]) m_ovf[t] = 0;
                m_prev[t] = b_pin[t];
            end
        end
    end

    function automatic logic [31:0] m_rd(input logic [3:0] a);
        logic [31:0] r;
        int slot, t;
        r = '0;
        if (a == 0) begin
            for (int k = 0; k < 3; k++) begin
                r[k] = m_run[k];
                r[8 + k] = m_ovf[k];
            end
        end else begin
            slot = int'(a) / 4;
            if (slot >= 1) begin
                t = slot - 1;
                case (int'(a) % 4)
                    0: r = 32'(m_cfg[t]);
                    1: r = 32'(m_cnt[t]);
                    2: r = 32'(m_per[t]);
                    default: r = 32'(m_wid[t]);
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        check("R1 readback", 64'(rdata), 64'(m_rd(b_addr)));
        for (int t = 0; t < 3; t++) begin
            check("R4 pin direction", 64'(pin_oe[t]), 64'(m_cfg[t] % 4 == 1));
            check("R5 waveform pin", 64'(pin_o[t]),
                  64'(m_run[t] && (m_cfg[t] % 4 == 1) && (m_cnt[t] < m_wid[t])));
            check("R6 R7 R8 interrupt", 64'(irq[t]), 64'(m_irq[t]));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        b_wr = 1'b1; b_addr = a; b_wd = d;
        @(posedge clk); #1;
        b_wr = 1'b0; b_wd = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rd_chk(input logic [3:0] a, input string req);
        b_addr = a;
        @(negedge clk);
        check(req, 64'(rdata), 64'(m_rd(a)));
    endtask

    task automatic rd_val(input logic [3:0] a, input logic [31:0] exp, input string req);
        b_addr = a;
        @(negedge clk);
        check(req, 64'(rdata), 64'(exp));
    endtask

    task automatic pin_pulse(input int t, input int h, input int l);
        b_pin[t] = 1'b1;
        repeat (h) begin @(posedge clk); #1; end
        b_pin[t] = 1'b0;
        repeat (l) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd_val(4'd0, 32'h0, "R2 control after reset");
        rd_val(4'd6, 32'h0, "R2 period after reset");
        check("R2 pins idle", 64'({pin_oe, pin_o, irq}), 64'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // waveform on timer 0
        wr(4'd4, 32'h1); wr(4'd6, 32'd6); wr(4'd7, 32'd2); wr(4'd0, 32'h1);
        idle(20);
        rd_chk(4'd5, "R5 count");
        wr(4'd6, 32'd3); idle(8);
        wr(4'd7, 32'd0); idle(5);
        wr(4'd7, 32'd9); idle(5);
        wr(4'd5, 32'hABCD);
        rd_chk(4'd5, "R11 count write ignored");
        rd_val(4'd6, 32'd3, "R11 period readback");

        // capture on timer 1
        wr(4'd8, 32'h2); wr(4'd0, 32'h2);
        repeat (3) pin_pulse(1, 5, 7);
        rd_val(4'd11, 32'd5, "R7 width");
        rd_val(4'd10, 32'd12, "R7 period");

        // watchdog on timer 2
        wr(4'd12, 32'h3); wr(4'd14, 32'd10); wr(4'd0, 32'h4);
        repeat (4) pin_pulse(2, 1, 5);
        rd_val(4'd0, 32'h007, "R8 fed watchdog");
        idle(8);
        wr(4'd0, 32'h40);
        rd_val(4'd0, 32'h403, "R8 timeout flag");
        wr(4'd0, 32'h400);
        rd_val(4'd0, 32'h003, "R9 clear flag");

        // stop behaviour
        wr(4'd0, 32'h10);
        rd_chk(4'd5, "R10 count frozen");
        idle(6);
        rd_chk(4'd5, "R10 count frozen");
        wr(4'd0, 32'h20);
        pin_pulse(1, 3, 3);
        rd_val(4'd11, 32'd5, "R10 capture frozen");

        // start/stop priority and restart
        wr(4'd0, 32'h11);
        rd_val(4'd0, 32'h000, "R3 stop wins");
        wr(4'd0, 32'h1);
        rd_val(4'd5, 32'h0, "R3 restart count");
        rd_val(4'd0, 32'h001, "R3 run flag");

        // idle mode holds count
        idle(3);
        wr(4'd4, 32'h3C);
        rd_val(4'd4, 32'h3C, "R4 config readback");
        rd_chk(4'd5, "R4 idle holds count");
        idle(5);
        rd_chk(4'd5, "R4 idle holds count");

        // short periods on timer 2
        wr(4'd12, 32'h1); wr(4'd14, 32'd1); wr(4'd15, 32'd1); wr(4'd0, 32'h4);
        idle(5);
        wr(4'd14, 32'd0);
        idle(5);
        rd_chk(4'd13, "R6 short period count");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule